// File: doc/BRIEF.md
# Multi-Channel 16-bit Timer/Counter

This block is a general-purpose 16-bit timer/counter for a larger chip. A register port configures it. The counter advances on a count enable that comes from one of four prescaler taps or from an edge on an external clock pin. It counts up or down and wraps at a TOP value that depends on the waveform mode.

Three compare channels each hold a buffered value and an active value. The counter is checked against the active values on every count step. A match sets that channel's flag and drives its waveform output. The output either toggles on a match, or forms a fast PWM signal that goes high at BOTTOM and low on the match.

A capture unit takes its trigger from a capture pin or from an analog comparator level. It runs the trigger through a synchronizer, an optional stability filter and an edge selector, and then stores the count. The overflow, compare and capture events land in one flag register. The flags are cleared by writing 1, and each flag can raise the interrupt line when its mask bit is set.

Top module: `mctimer16`

## Requirements
- R1: After reset the counter, compare buffers, capture register, flags, mask, control and capture-control registers read 0, the TOP register reads 0xFFFF, and all waveform outputs and the interrupt are low. The register addresses are:
  - 0: control
  - 1: capture control
  - 2: count
  - 3, 4, 5: compare channels 0, 1 and 2
  - 6: capture (read-only)
  - 7: flags
  - 8: mask
  - 9: TOP
- R2: Control bits [4:2] select the count enable. Code 0 and code 7 stop the counter. Codes 1 to 4 use prescaler tap bits 0 to 3. The counter changes only on a selected enable or on a write to the count register, and the write takes priority.
- R3: Code 6 counts rising edges and code 5 counts falling edges of the external clock pin. The pin passes through a two-flop synchronizer, so exactly one step is taken per selected edge as long as the pin changes more slowly than half the system clock.
- R4: When control bit 5 is 1 the counter counts down, except in fast PWM mode, which always counts up. Counting up wraps from TOP to 0, and counting down wraps from 0 to TOP. Each wrap sets overflow flag bit 0.
- R5: Control bits [1:0] select the mode, and the mode sets TOP:
  - 0, normal: TOP is 0xFFFF.
  - 1, clear-on-match: TOP is the active value of compare channel 0.
  - 2, fast PWM: TOP is the TOP register.
  - 3: behaves as normal.
- R6: A count step that makes the count equal to a channel's active compare value sets flag bit 1, 2 or 3 for channel 0, 1 or 2.
- R7: In normal and clear-on-match modes, each match event toggles that channel's waveform output.
- R8: In fast PWM mode a channel's output goes high on the wrap to 0 and low on a match. If both happen on the same step, the match wins.
- R9: A compare write lands in the buffer, which is what reads return. In normal and clear-on-match modes the active value follows the buffer one cycle later. In fast PWM mode it is loaded only on a wrap.
- R10: Capture-control bit 0 selects the trigger: 0 is the capture pin, 1 is the comparator input. Bit 1 selects the edge: 1 is rising, 0 is falling. On the selected edge the capture register stores the count and flag bit 4 is set.
- R11: When capture-control bit 2 is 1, a new trigger level is accepted only after 4 consecutive equal synchronized samples. Pulses of 3 cycles or shorter never cause a capture.
- R12: Writing 1 to a flag bit clears it. A hardware set in the same cycle wins over the clear.
- R13: The interrupt output is high whenever any flag is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| presc_tick | input | 4 | Prescaler tap enables |
| ext_clk | input | 1 | External count clock pin |
| cap_pin | input | 1 | Capture trigger pin |
| acmp_out | input | 1 | Analog comparator level, alternate capture trigger |
| wave_out | output | 3 | Compare channel waveform outputs |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions rely on three conditions:
- The external clock pin changes no faster than every other system clock.
- The capture source and edge polarity are changed only while the selected trigger is low, so a configuration change never looks like an edge.
- Compare and count registers are not written during the step under observation.

The stimulus follows these conditions by construction:
- The stimulus holds each external pin level for at least three cycles.
- It reconfigures capture only with both triggers at 0.
- It waits several cycles after the last pin change before it stops the counter.
- It sweeps the prescaler taps, both counting directions, all modes and both capture sources with computed expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned N_TAPS = 4;
    localparam int unsigned TAP_IW = $clog2(N_TAPS);

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_CTC  = 2'd1,
        MODE_FPWM = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    localparam logic [2:0] CS_OFF      = 3'd0;
    localparam logic [2:0] CS_EXT_FALL = 3'd5;
    localparam logic [2:0] CS_EXT_RISE = 3'd6;
    localparam logic [2:0] CS_OFF_ALT  = 3'd7;

    typedef struct packed {
        logic [1:0] spare;
        logic       dir;
        logic [2:0] csel;
        mode_e      mode;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] spare;
        logic       filt_en;
        logic       rise;
        logic       src_cmp;
    } capc_t;

    localparam logic [ADDR_W-1:0] RA_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] RA_CAPC = 4'd1;
    localparam logic [ADDR_W-1:0] RA_CNT  = 4'd2;
    localparam logic [ADDR_W-1:0] RA_CMP0 = 4'd3;
    localparam logic [ADDR_W-1:0] RA_CAPT = 4'd6;
    localparam logic [ADDR_W-1:0] RA_FLAG = 4'd7;
    localparam logic [ADDR_W-1:0] RA_MASK = 4'd8;
    localparam logic [ADDR_W-1:0] RA_TOP  = 4'd9;

    function automatic logic [ADDR_W-1:0] cmp_addr(input int unsigned idx);
        return RA_CMP0 + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/tmr_clksel.sv
module tmr_clksel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        csel,
    input  logic [N_TAPS-1:0] taps,
    input  logic              ext_pin,
    output logic              tick
);

    // sh[0], sh[1]: synchronizer; sh[2]: previous synchronized level
    logic [2:0] sh;
    logic       ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], ext_pin};
    end

    assign ext_rise = sh[1] & ~sh[2];
    assign ext_fall = ~sh[1] & sh[2];

    always_comb begin
        tick = 1'b0;
        if (csel == CS_EXT_FALL)      tick = ext_fall;
        else if (csel == CS_EXT_RISE) tick = ext_rise;
        else if (csel != CS_OFF && csel != CS_OFF_ALT)
            tick = taps[TAP_IW'(csel - 3'd1)];
    end

    // R2
    stop_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (csel == CS_OFF || csel == CS_OFF_ALT) |-> !tick);

    // R3
    ext_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (csel == CS_EXT_RISE && tick) |=> (csel != CS_EXT_RISE || !tick));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_cmp,
    input  logic             rise,
    input  logic             filt_en,
    input  logic             pin,
    input  logic             acmp,
    input  logic [CNT_W-1:0] cnt,
    output logic             evt,
    output logic [CNT_W-1:0] cap_val
);

    logic                raw, s1, s2, filt, lvl, lvl_d;
    logic [FILT_LEN-1:0] hist;

    assign raw = src_cmp ? acmp : pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            hist  <= '0;
            filt  <= 1'b0;
            lvl_d <= 1'b0;
        end else begin
            s1    <= raw;
            s2    <= s1;
            hist  <= {hist[FILT_LEN-2:0], s2};
            if (&hist)       filt <= 1'b1;
            else if (~|hist) filt <= 1'b0;
            lvl_d <= lvl;
        end
    end

    assign lvl = filt_en ? filt : s2;
    assign evt = rise ? (lvl & ~lvl_d) : (~lvl & lvl_d);

    always_ff @(posedge clk) begin
        if (rst)      cap_val <= '0;
        else if (evt) cap_val <= cnt;
    end

    // R11
    filt_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!filt && !(&hist)) |=> !filt);

    // R10
    cap_latch_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cap_val == $past(cnt)));

endmodule

// File: rtl/tmr_cmpch.sv
module tmr_cmpch
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             buf_wr,
    input  logic [CNT_W-1:0] wdata,
    input  mode_e            mode,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] buffered,
    output logic             match,
    output logic             wave
);

    logic pwm;

    assign pwm   = (mode == MODE_FPWM);
    assign match = tick && (cnt_nxt == active);

    always_ff @(posedge clk) begin
        if (rst) begin
            buffered <= '0;
            active   <= '0;
            wave     <= 1'b0;
        end else begin
            if (buf_wr) buffered <= wdata;
            if (!pwm || wrap) active <= buffered;
            if (pwm) begin
                if (match)     wave <= 1'b0;
                else if (wrap) wave <= 1'b1;
            end else if (match) begin
                wave <= ~wave;
            end
        end
    end

    // R9
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm && !wrap) |=> $stable(active));

    // R8
    pwm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm && match) |=> !wave);

endmodule

// File: rtl/mctimer16.sv
module mctimer16
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned N_CMP    = 3,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [N_TAPS-1:0] presc_tick,
    input  logic              ext_clk,
    input  logic              cap_pin,
    input  logic              acmp_out,
    output logic [N_CMP-1:0]  wave_out,
    output logic              irq
);

    localparam int unsigned NFLG = N_CMP + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t            ctrl;
    capc_t            capc;
    logic [CNT_W-1:0] cnt, top_reg, top_val, cnt_nxt, cap_val;
    logic [CNT_W-1:0] cmp_act [N_CMP];
    logic [CNT_W-1:0] cmp_buf [N_CMP];
    logic [N_CMP-1:0] match;
    logic [NFLG-1:0]  flags, mask, set_vec, clr_vec;
    logic             tick, tick_eff, cnt_wr, down, at_end, wrap_evt, cap_evt;

    tmr_clksel u_clksel (
        .clk     (clk),
        .rst     (rst),
        .csel    (ctrl.csel),
        .taps    (presc_tick),
        .ext_pin (ext_clk),
        .tick    (tick)
    );

    tmr_capture #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .src_cmp (capc.src_cmp),
        .rise    (capc.rise),
        .filt_en (capc.filt_en),
        .pin     (cap_pin),
        .acmp    (acmp_out),
        .cnt     (cnt),
        .evt     (cap_evt),
        .cap_val (cap_val)
    );

    assign cnt_wr   = wr_en && (wr_addr == RA_CNT);
    assign tick_eff = tick && !cnt_wr;
    assign down     = ctrl.dir && (ctrl.mode != MODE_FPWM);

    always_comb begin
        case (ctrl.mode)
            MODE_CTC:  top_val = cmp_act[0];
            MODE_FPWM: top_val = top_reg;
            default:   top_val = CNT_MAX;
        endcase
    end

    assign at_end   = down ? (cnt == '0) : (cnt == top_val);
    assign wrap_evt = tick_eff && at_end;

    always_comb begin
        if (at_end)    cnt_nxt = down ? top_val : '0;
        else if (down) cnt_nxt = cnt - 1'b1;
        else           cnt_nxt = cnt + 1'b1;
    end

    for (genvar g = 0; g < N_CMP; g++) begin : g_ch
        tmr_cmpch #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .buf_wr   (wr_en && (wr_addr == cmp_addr(g))),
            .wdata    (wr_data),
            .mode     (ctrl.mode),
            .tick     (tick_eff),
            .wrap     (wrap_evt),
            .cnt_nxt  (cnt_nxt),
            .active   (cmp_act[g]),
            .buffered (cmp_buf[g]),
            .match    (match[g]),
            .wave     (wave_out[g])
        );
    end

    assign set_vec = {cap_evt, match, wrap_evt};
    assign clr_vec = (wr_en && wr_addr == RA_FLAG) ? wr_data[NFLG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            capc    <= '0;
            cnt     <= '0;
            top_reg <= CNT_MAX;
            flags   <= '0;
            mask    <= '0;
        end else begin
            if (wr_en && wr_addr == RA_CTRL) ctrl    <= ctrl_t'(wr_data[7:0]);
            if (wr_en && wr_addr == RA_CAPC) capc    <= capc_t'(wr_data[7:0]);
            if (wr_en && wr_addr == RA_MASK) mask    <= wr_data[NFLG-1:0];
            if (wr_en && wr_addr == RA_TOP)  top_reg <= wr_data;
            if (cnt_wr)        cnt <= wr_data;
            else if (tick_eff) cnt <= cnt_nxt;
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(flags & mask);

    always_comb begin
        rd_data = '0;
        if (rd_addr == RA_CTRL)      rd_data[7:0]      = ctrl;
        else if (rd_addr == RA_CAPC) rd_data[7:0]      = capc;
        else if (rd_addr == RA_CNT)  rd_data           = cnt;
        else if (rd_addr == RA_CAPT) rd_data           = cap_val;
        else if (rd_addr == RA_FLAG) rd_data[NFLG-1:0] = flags;
        else if (rd_addr == RA_MASK) rd_data[NFLG-1:0] = mask;
        else if (rd_addr == RA_TOP)  rd_data           = top_reg;
        for (int unsigned i = 0; i < N_CMP; i++)
            if (rd_addr == cmp_addr(i)) rd_data = cmp_buf[i];
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_eff && !cnt_wr) |=> $stable(cnt));

    // R4
    up_wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_eff && at_end && !down) |=> (cnt == '0));

    // R12
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

endmodule

// File: tb/mctimer16_tb.sv
module mctimer16_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  presc_tick = '0;
    logic        ext_clk = 1'b0;
    logic        cap_pin = 1'b0;
    logic        acmp_out = 1'b0;
    logic [2:0]  wave_out;
    logic        irq;

    int total = 0;
    int bad = 0;

    localparam logic [3:0] A_CTRL = 0, A_CAPC = 1, A_CNT = 2, A_CMPA = 3, A_CMPB = 4,
                           A_CMPC = 5, A_CAPT = 6, A_FLAG = 7, A_MASK = 8, A_TOP = 9;

    always #10 clk = ~clk;

    mctimer16 u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .presc_tick(presc_tick), .ext_clk(ext_clk),
        .cap_pin(cap_pin), .acmp_out(acmp_out), .wave_out(wave_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        presc_tick = 4'b0001;
        idle(n);
        presc_tick = 4'b0000;
    endtask

    task automatic pulse(input bit use_acmp, input int n);
        if (use_acmp) acmp_out = 1'b1; else cap_pin = 1'b1;
        idle(n);
        acmp_out = 1'b0; cap_pin = 1'b0;
        idle(14);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [2:0]  w0;
        int          exp_cnt;

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset values
        rd(A_CNT, v);  chk("R1 count", v, 16'h0000);
        rd(A_FLAG, v); chk("R1 flags", v, 16'h0000);
        rd(A_TOP, v);  chk("R1 top", v, 16'hFFFF);
        rd(A_CMPB, v); chk("R1 cmpB", v, 16'h0000);
        rd(A_CAPT, v); chk("R1 capt", v, 16'h0000);
        chk("R1 wave", {13'b0, wave_out}, 16'h0000);
        chk("R1 irq", {15'b0, irq}, 16'h0000);

        // R2: prescaler tap sweep, tap i pulses every (i+1) cycles
        for (int tap = 0; tap < 4; tap++) begin
            wr(A_CNT, 16'h0000);
            wr(A_CTRL, 16'((tap + 1) << 2));
            exp_cnt = 0;
            for (int k = 0; k < 23; k++) begin
                for (int b = 0; b < 4; b++) presc_tick[b] = ((k % (b + 1)) == 0);
                if (presc_tick[tap]) exp_cnt++;
                @(negedge clk);
            end
            presc_tick = '0;
            wr(A_CTRL, 16'h0000);
            rd(A_CNT, v);
            chk($sformatf("R2 tap%0d count", tap), v, 16'(exp_cnt));
        end

        // R2: codes 0 and 7 keep the counter still
        wr(A_CNT, 16'h0010);
        presc_tick = 4'hF;
        idle(8);
        wr(A_CTRL, 16'h001C);
        idle(8);
        presc_tick = 4'h0;
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v); chk("R2 stopped count", v, 16'h0010);

        // R4: down count wrap 2,1,0,FFFF,FFFE
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'h0002);
        wr(A_CTRL, 16'h0024);
        run_ticks(4);
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v);  chk("R4 down wrap count", v, 16'hFFFE);
        rd(A_FLAG, v); chk("R4 down overflow flag", v & 16'h0001, 16'h0001);

        // R4: up count wrap in normal mode
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'hFFFE);
        wr(A_CTRL, 16'h0004);
        run_ticks(3);
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v);  chk("R4 up wrap count", v, 16'h0001);
        rd(A_FLAG, v); chk("R4 up overflow flag", v & 16'h0001, 16'h0001);

        // R12: hardware set wins over a same-cycle clear
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'hFFFF);
        presc_tick = 4'b0001;
        wr(A_CTRL, 16'h0004);
        wr(A_FLAG, 16'h0001);
        wr(A_CTRL, 16'h0000);
        presc_tick = 4'b0000;
        rd(A_FLAG, v); chk("R12 set wins", v & 16'h0001, 16'h0001);
        wr(A_FLAG, 16'h0001);
        rd(A_FLAG, v); chk("R12 write-one clears", v & 16'h0001, 16'h0000);

        // R6 R7: matches in normal mode
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'h0000);
        wr(A_CMPA, 16'd3);
        wr(A_CMPB, 16'd5);
        wr(A_CMPC, 16'd7);
        w0 = wave_out;
        wr(A_CTRL, 16'h0004);
        run_ticks(8);
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v);  chk("R6 count after run", v, 16'd8);
        rd(A_FLAG, v); chk("R6 compare flags", v, 16'h000E);
        chk("R7 toggled once", {13'b0, wave_out}, {13'b0, w0 ^ 3'b111});
        rd(A_CMPC, v); chk("R9 buffer readback", v, 16'd7);

        // R13: interrupt masking
        wr(A_MASK, 16'h0004);
        chk("R13 masked flag raises irq", {15'b0, irq}, 16'h0001);
        wr(A_MASK, 16'h0001);
        chk("R13 unset flag no irq", {15'b0, irq}, 16'h0000);
        wr(A_MASK, 16'h0000);

        // R7: no matches, then toggles back
        wr(A_CTRL, 16'h0004);
        run_ticks(8);
        wr(A_CTRL, 16'h0000);
        chk("R7 no match keeps wave", {13'b0, wave_out}, {13'b0, w0 ^ 3'b111});
        wr(A_CNT, 16'h0000);
        wr(A_CTRL, 16'h0004);
        run_ticks(8);
        wr(A_CTRL, 16'h0000);
        chk("R7 second toggle", {13'b0, wave_out}, {13'b0, w0});

        // R5: clear-on-match with TOP = 4
        wr(A_FLAG, 16'h001F);
        wr(A_CMPA, 16'd4);
        wr(A_CNT, 16'h0000);
        wr(A_CTRL, 16'h0005);
        run_ticks(12);
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v);  chk("R5 ctc count", v, 16'd2);
        rd(A_FLAG, v); chk("R5 ctc flags", v & 16'h0003, 16'h0003);

        // R5: mode 3 acts as normal
        wr(A_CNT, 16'd3);
        wr(A_CTRL, 16'h0007);
        run_ticks(3);
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v); chk("R5 mode3 count", v, 16'd6);

        // R8 R9: fast PWM, TOP = 9, channel 1 threshold 3 then 6
        begin
            int  thr = 3, wraps = 0, mism = 0, highs = 0;
            bit  pend = 0, written = 0;
            logic [15:0] c;
            wr(A_TOP, 16'd9);
            wr(A_CMPB, 16'd3);
            wr(A_CNT, 16'd9);
            presc_tick = 4'b0001;
            wr(A_CTRL, 16'h0006);
            for (int k = 0; k < 60; k++) begin
                wr_en = 1'b0;
                rd(A_CNT, c);
                if (c == 16'd0) begin
                    wraps++;
                    if (pend) begin thr = 6; pend = 0; end
                end
                if (wraps > 0) begin
                    if (wave_out[1] !== (int'(c) < thr)) mism++;
                    if (wave_out[1]) highs++;
                end
                if (wraps == 2 && c == 16'd0 && !written) begin
                    wr_en = 1'b1; wr_addr = A_CMPB; wr_data = 16'd6;
                    written = 1; pend = 1;
                end
                @(negedge clk);
            end
            wr_en = 1'b0;
            presc_tick = 4'b0000;
            wr(A_CTRL, 16'h0000);
            chk("R8 R9 pwm waveform mismatches", 16'(mism), 16'd0);
            chk("R9 new duty took effect after wrap", {15'b0, (written && !pend)}, 16'h0001);
            chk("R8 high cycles seen", {15'b0, (highs > 20)}, 16'h0001);
        end

        // R3: external rising edges
        wr(A_CNT, 16'h0000);
        wr(A_CTRL, 16'h0018);
        idle(4);
        for (int k = 0; k < 5; k++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        idle(4);
        wr(A_CTRL, 16'h0000);
        rd(A_CNT, v); chk("R3 rising edges", v, 16'd5);

        // R3: external falling edges, 4 falls and 5 rises
        wr(A_CNT, 16'h0000);
        wr(A_CTRL, 16'h0014);
        idle(4);
        for (int k = 0; k < 4; k++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        ext_clk = 1'b1;
        idle(6);
        wr(A_CTRL, 16'h0000);
        ext_clk = 1'b0;
        idle(4);
        rd(A_CNT, v); chk("R3 falling edges", v, 16'd4);

        // R10: pin capture, rising, unfiltered
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'h1234);
        wr(A_CAPC, 16'h0002);
        pulse(0, 3);
        rd(A_CAPT, v); chk("R10 capture value", v, 16'h1234);
        rd(A_FLAG, v); chk("R10 capture flag", v & 16'h0010, 16'h0010);

        // R11: filter rejects a 3-cycle pulse, accepts a 6-cycle one
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'h2222);
        wr(A_CAPC, 16'h0006);
        pulse(0, 3);
        rd(A_CAPT, v); chk("R11 short pulse ignored", v, 16'h1234);
        rd(A_FLAG, v); chk("R11 short pulse no flag", v & 16'h0010, 16'h0000);
        pulse(0, 6);
        rd(A_CAPT, v); chk("R11 long pulse captured", v, 16'h2222);

        // R10: falling edge selection
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'h3333);
        wr(A_CAPC, 16'h0000);
        cap_pin = 1'b1;
        idle(12);
        rd(A_FLAG, v); chk("R10 rising ignored when falling selected", v & 16'h0010, 16'h0000);
        cap_pin = 1'b0;
        idle(12);
        rd(A_CAPT, v); chk("R10 falling capture", v, 16'h3333);

        // R10: comparator source
        wr(A_FLAG, 16'h001F);
        wr(A_CNT, 16'h4444);
        wr(A_CAPC, 16'h0003);
        pulse(0, 6);
        rd(A_CAPT, v); chk("R10 pin ignored with comparator source", v, 16'h3333);
        pulse(1, 6);
        rd(A_CAPT, v); chk("R10 comparator capture", v, 16'h4444);

        finish_run();
    end

endmodule